// File: doc/BRIEF.md
# Dual-Reload PWM Timer Channel

This block is one timer channel that draws a duty-cycle waveform on a single flip-flop output. A 16-bit down counter is loaded from one of two reload registers and steps once per count-clock strobe. Each time it passes zero it inverts the output and loads the other reload value. The high and low phases therefore last (first reload + 1) and (second reload + 1) strobes.

Software writes the two reload values and a control word through a small write port. In continuous mode the channel runs until software stops it. In single-shot mode it produces one pulse pair and then stops. A one-cycle request pulse marks the completion of each full period, and can serve as an interrupt or a DMA trigger.

Top module: `dpwm_channel`

## Requirements
- R1: After a synchronous reset `wave_out`, `req_out` and `busy` are all 0, and both reload registers read as 0 in effect.
- R2: After a start, the first phase lasts reload-0 + 1 strobes and the second lasts reload-1 + 1 strobes. In continuous mode the phases keep alternating between the two registers. A reload value of 0 gives a one-strobe phase.
- R3: In continuous mode (control bit 1 = 0), `wave_out` inverts on the clock edge that accepts the start write, and again on every underflow.
- R4: In continuous mode, `req_out` is high for exactly one cycle after the edge of every second underflow (the 2nd, 4th, …) since the start.
- R5: In single-shot mode (control bit 1 = 1), `wave_out` does not change at the start and inverts on each of the two underflows.
- R6: In single-shot mode, the second underflow raises `req_out` for one cycle and clears `busy` on the same edge. After that, strobes have no effect.
- R7: A control write with bit 0 = 0 stops the counter on that edge at any point in the period. `wave_out` holds its level, and a later start begins again from reload 0.
- R8: A write to a reload register (select 0 or 1) may happen at any time. The new value is used at the next load from that register, and a load on the same edge as the write uses the old value.
- R9: A control write with bit 0 = 1 while `busy` is 1 is ignored, including its mode bit.
- R10: The counter advances only on cycles where `cnt_stb` is 1. Strobes while the channel is stopped have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the register port |
| wr_sel | input | 2 | Target: 0 = reload 0, 1 = reload 1, 2 = control (bit 0 enable, bit 1 single-shot) |
| wr_data | input | 16 | Write data |
| cnt_stb | input | 1 | Count-clock enable strobe |
| wave_out | output | 1 | Waveform flip-flop output |
| req_out | output | 1 | One-cycle interrupt/DMA request pulse |
| busy | output | 1 | Enable bit; self-clears at single-shot completion |

## Verification
Every result is registered, so each one appears exactly one clock after the edge that caused it. A start write or an underflowing strobe on edge k changes `wave_out`, `req_out` and `busy` in the cycle that follows edge k. The bench drives inputs just after a falling edge, and a behavioural reference model counts the remaining strobes per phase. It compares all three outputs at every falling edge, so a result that comes one cycle early or late shows up as a miscompare. Strobe patterns include every cycle, every third cycle and pseudo-random spacing, so phase lengths are checked in strobes and not in clocks.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  typedef enum logic {
    MODE_CONT = 1'b0,
    MODE_SHOT = 1'b1
  } tmr_mode_e;

  typedef enum logic [1:0] {
    SEL_RLD0 = 2'd0,
    SEL_RLD1 = 2'd1,
    SEL_CTRL = 2'd2
  } wr_target_e;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_MODE_BIT = 1;
endpackage

// File: rtl/dpwm_regs.sv
module dpwm_regs
  import dpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rld0,
  output logic [CNT_W-1:0] rld1,
  output logic             ctl_wr,
  output logic             ctl_en,
  output tmr_mode_e        ctl_mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rld0 <= '0;
      rld1 <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_RLD0) rld0 <= wr_data;
      if (wr_sel == SEL_RLD1) rld1 <= wr_data;
    end
  end

  assign ctl_wr   = wr_en && (wr_sel == SEL_CTRL);
  assign ctl_en   = wr_data[CTL_EN_BIT];
  assign ctl_mode = tmr_mode_e'(wr_data[CTL_MODE_BIT]);
endmodule

// File: rtl/dpwm_core.sv
module dpwm_core
  import dpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             stb_i,
  input  tmr_mode_e        mode_i,
  input  logic [CNT_W-1:0] rld0,
  input  logic [CNT_W-1:0] rld1,
  output logic             running,
  output tmr_mode_e        mode_q,
  output logic             ufl,
  output logic             ufl_even
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] cnt;
  logic             phase;  // 0: reload-0 phase, 1: reload-1 phase

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return v - 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] next_load(input logic ph,
                                                 input logic [CNT_W-1:0] a,
                                                 input logic [CNT_W-1:0] b);
    return ph ? a : b;
  endfunction

  assign ufl      = running && stb_i && !stop_i && (cnt == CNT_ZERO);
  assign ufl_even = ufl && phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      mode_q  <= MODE_CONT;
      cnt     <= '0;
      phase   <= 1'b0;
    end else if (stop_i) begin
      running <= 1'b0;
    end else if (start_i) begin
      running <= 1'b1;
      mode_q  <= mode_i;
      cnt     <= rld0;
      phase   <= 1'b0;
    end else if (running && stb_i) begin
      if (ufl) begin
        cnt   <= next_load(phase, rld0, rld1);
        phase <= ~phase;
        if (phase && mode_q == MODE_SHOT) running <= 1'b0;
      end else begin
        cnt <= step_down(cnt);
      end
    end
  end

  // R7
  stop_halts_chk: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> !running);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!stb_i && !start_i && !stop_i) |=> $stable(cnt) && $stable(phase));
  // R6
  shot_end_chk: assert property (@(posedge clk) disable iff (rst)
    (ufl_even && mode_q == MODE_SHOT) |=> !running);
endmodule

// File: rtl/dpwm_out.sv
module dpwm_out (
  input  logic clk,
  input  logic rst,
  input  logic tog_start,
  input  logic ufl,
  input  logic ufl_even,
  output logic wave,
  output logic req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wave <= 1'b0;
      req  <= 1'b0;
    end else begin
      wave <= wave ^ (tog_start || ufl);
      req  <= ufl_even;
    end
  end

  // R3
  ufl_flip_chk: assert property (@(posedge clk) disable iff (rst)
    ufl |=> (wave != $past(wave)));
  // R4
  req_single_chk: assert property (@(posedge clk) disable iff (rst)
    req |=> !req);
endmodule

// File: rtl/dpwm_channel.sv
module dpwm_channel
  import dpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             cnt_stb,
  output logic             wave_out,
  output logic             req_out,
  output logic             busy
);
  logic [CNT_W-1:0] rld0, rld1;
  logic             ctl_wr, ctl_en;
  tmr_mode_e        ctl_mode, mode_q;
  logic             start_evt, stop_evt, ufl, ufl_even, cont_start;

  dpwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rld0(rld0), .rld1(rld1), .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_mode(ctl_mode)
  );

  assign start_evt  = ctl_wr && ctl_en && !busy;
  assign stop_evt   = ctl_wr && !ctl_en;
  assign cont_start = start_evt && (ctl_mode == MODE_CONT);

  dpwm_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .start_i(start_evt), .stop_i(stop_evt), .stb_i(cnt_stb),
    .mode_i(ctl_mode), .rld0(rld0), .rld1(rld1), .running(busy), .mode_q(mode_q),
    .ufl(ufl), .ufl_even(ufl_even)
  );

  dpwm_out u_out (
    .clk(clk), .rst(rst), .tog_start(cont_start), .ufl(ufl), .ufl_even(ufl_even),
    .wave(wave_out), .req(req_out)
  );

  // R5
  shot_start_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (start_evt && ctl_mode == MODE_SHOT) |=> $stable(wave_out));
  // R9
  restart_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_en && busy) |=> $stable(mode_q));
  // R6
  shot_req_chk: assert property (@(posedge clk) disable iff (rst)
    (req_out && mode_q == MODE_SHOT) |-> !busy);
endmodule

// File: tb/sim_dpwm_channel.sv
module sim_dpwm_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        cnt_stb = 1'b0;
  logic        wave_out, req_out, busy;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  string tag = "R1";
  logic [7:0] lfsr = 8'h5B;

  // reference model state
  int m_r0 = 0, m_r1 = 0, m_left = 0;
  bit m_en = 0, m_one = 0, m_ph = 0, m_wave = 0, m_req = 0;

  always #2 clk = ~clk;  // 250 MHz

  dpwm_channel u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cnt_stb(cnt_stb), .wave_out(wave_out), .req_out(req_out), .busy(busy)
  );

  // Behavioural model: counts strobes remaining in the current phase.
  always @(posedge clk) begin
    m_req = 0;
    if (rst) begin
      m_r0 = 0; m_r1 = 0; m_left = 0; m_en = 0; m_one = 0; m_ph = 0; m_wave = 0;
    end else begin
      if (wr_en && wr_sel == 2'd2 && !wr_data[0]) m_en = 0;
      else if (wr_en && wr_sel == 2'd2 && !m_en) begin
        m_en = 1; m_one = wr_data[1]; m_left = m_r0 + 1; m_ph = 0;
        if (!m_one) m_wave = !m_wave;
      end else if (m_en && cnt_stb) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_wave = !m_wave;
          if (m_ph) begin
            m_req = 1;
            if (m_one) m_en = 0;
          end
          m_left = (m_ph ? m_r0 : m_r1) + 1;
          m_ph = !m_ph;
        end
      end
      if (wr_en && wr_sel == 2'd0) m_r0 = wr_data;
      if (wr_en && wr_sel == 2'd1) m_r1 = wr_data;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // one clock: inputs already driven; compare after the edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    check(tag, "wave_out", wave_out, m_wave);
    check(tag, "req_out", req_out, m_req);
    check(tag, "busy", busy, m_en);
    wr_en = 0;
  endtask

  task automatic wr(input logic [1:0] sel, input int data, input bit stb);
    wr_en = 1; wr_sel = sel; wr_data = 16'(data); cnt_stb = stb;
    tick();
  endtask

  // run n cycles; pat 0 = every cycle, 3 = every third, 1 = pseudo-random
  task automatic run(input int n, input int pat);
    for (int i = 0; i < n; i++) begin
      if (pat == 0) cnt_stb = 1;
      else if (pat == 3) cnt_stb = (i % 3 == 2);
      else begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        cnt_stb = lfsr[0];
      end
      tick();
    end
    cnt_stb = 0;
  endtask

  always @(posedge clk) begin
    if (cyc >= 100000) begin
      miscompares++;
      $display("FAIL all watchdog actual=%0d expected<100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    tag = "R1"; tick(); tick();
    rst = 0; tick();

    // R2 R3 R4: continuous, strobe every cycle
    tag = "R3";
    wr(2'd0, 3, 0); wr(2'd1, 1, 0); wr(2'd2, 1, 0);
    tag = "R4"; run(30, 0);
    wr(2'd2, 0, 0);

    // R10: sparse strobes; strobes while stopped
    tag = "R10";
    run(8, 0);
    wr(2'd0, 2, 0); wr(2'd1, 4, 0); wr(2'd2, 1, 1);
    run(60, 3);

    // R7: stop mid-phase, hold, restart from reload 0
    tag = "R7";
    run(2, 0);
    wr(2'd2, 0, 1);
    run(10, 0);
    wr(2'd2, 1, 0);
    run(12, 0);

    // R9: enable write with single-shot bit while running
    tag = "R9";
    wr(2'd2, 3, 1);
    run(15, 0);
    wr(2'd2, 0, 0);

    // R5 R6: single-shot
    tag = "R5";
    wr(2'd0, 2, 0); wr(2'd1, 3, 0); wr(2'd2, 3, 0);
    tag = "R6"; run(20, 0);
    check("R6", "busy after shot", busy, 0);
    run(5, 0);
    wr(2'd2, 3, 1);
    run(25, 1);
    check("R6", "busy after random shot", busy, 0);

    // R8: reload writes while running, incl. same-edge as a load
    tag = "R8";
    wr(2'd0, 1, 0); wr(2'd1, 2, 0); wr(2'd2, 1, 0);
    wr(2'd1, 5, 1);
    run(3, 0);
    wr(2'd0, 4, 1);
    wr(2'd0, 0, 1);
    run(30, 0);
    wr(2'd2, 0, 0);

    // R2: zero reloads give one-strobe phases
    tag = "R2";
    wr(2'd0, 0, 0); wr(2'd1, 0, 0); wr(2'd2, 1, 1);
    run(12, 0);
    wr(2'd0, 5, 0); wr(2'd1, 7, 0);
    run(300, 1);
    wr(2'd2, 0, 0);

    // R1: reset in mid-run clears everything
    tag = "R1";
    wr(2'd2, 1, 0); run(3, 0);
    rst = 1; tick();
    check("R1", "wave after reset", wave_out, 0);
    check("R1", "busy after reset", busy, 0);
    rst = 0; wr(2'd2, 3, 0);
    run(4, 0);
    check("R1", "zero reload shot done", busy, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule